// File: doc/BRIEF.md
# Two-Tone Audio Burst Transmitter

This block turns a stream of bytes into a stream of 8-bit unsigned audio samples. Each sample is one point of a sine wave that carries serial data at a fixed bit rate, using two tones. One sample is produced for each pulse of a sample-rate strobe. A burst starts with a start pulse. The burst then has these parts, in order:

1. A run of flag bytes (0x7E) as preamble.
2. The queued bytes.
3. A run of flag bytes as tail.

The block then falls idle and its output returns to zero.

Line coding is NRZI: a 0 bit changes the tone and a 1 bit keeps it. Data bits are sent least significant bit first. After five 1 bits in a row of stuffable data, the block inserts an extra tone change. A flag byte (0x7E) or abort byte (0x7F) taken from the queue goes out unstuffed, so the far end sees it as a real marker. An escape byte (0x1B) is not sent. Instead, the byte that follows it goes out as ordinary stuffed data, even if that byte has a marker value.

The tone generator is a 9-bit phase accumulator. It reads a 128-entry quarter-wave table and unfolds it into a full 512-step sine period. Bytes arrive on a valid/ready handshake into a one-byte holding stage. A start pulse during a burst only refills the tail count.

Top module: `fsk_burst_tx`

## Requirements
- R1: After reset, `busy`, `abort` and `sample_out` are 0, and `byte_ready` is 1.
- R2: Quarter-table entry i (0..127) is round(128 + 127·sin(π·i/256)). For a phase p, let r = p mod 256. The lookup index is r when r < 128, and 255 − r otherwise. When p ≥ 256 the sample is 255 minus the entry.
- R3: On every strobe of a burst, the phase grows by round(512·f/sample_rate) modulo 512, where f is the current tone. This gives 64 for the 1200 Hz mark tone and 117 for the 2200 Hz space tone. The sample is the sine of the new phase and is registered on that strobe edge.
- R4: Each line bit, including an inserted stuffing change, lasts sample_rate/bit_rate strobes. This is 8 strobes by default. The tone changes only on the first strobe of a line bit.
- R5: A burst starts on the mark tone with the phase at 0. A data 0 changes the tone and a data 1 keeps it. Bits go out least significant bit first.
- R6: In stuffable data, five consecutive 1 bits cause one inserted tone change before the next data bit, and the run count then restarts. A 0 bit also clears the count. The count carries across the boundary between two stuffable bytes.
- R7: Flags and abort bytes (0x7E and 0x7F) go out unstuffed, whether they come from the queue, the preamble or the tail. The run count is cleared at the start of the byte that follows such a byte.
- R8: An escape byte (0x1B) from the queue is dropped. The next queued byte is sent as stuffable data, whatever its value.
- R9: The preamble has round(pre_ms·bit_rate/8000) flags, sent before any queued byte. The tail has round(tail_ms·bit_rate/8000) flags, sent once the queue is empty. The defaults give 3 and 2.
- R10: The burst ends on the strobe at a byte boundary where the queue is empty and the tail count is 0. On that same edge, `sample_out` becomes 0 and `busy` falls. While idle, `sample_out` stays 0.
- R11: An escape byte with no byte behind it ends the burst on that strobe, as in R10. `abort` is then high for exactly one clock.
- R12: A start pulse during a burst does not restart the preamble, the tone or the phase.
- R13: `byte_ready` is high while the holding stage is empty, and when that stage is being emptied on a byte-boundary strobe. Every queued byte is consumed by the end of the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_en | input | 1 | Sample-rate strobe, one clock wide |
| start | input | 1 | Begin a burst, or refill the tail count while a burst is running |
| byte_data | input | 8 | Queued byte |
| byte_valid | input | 1 | `byte_data` holds a byte |
| byte_ready | output | 1 | Byte accepted on this clock when `byte_valid` is also high |
| sample_out | output | 8 | Unsigned audio sample |
| busy | output | 1 | A burst is in progress |
| abort | output | 1 | One-clock pulse: an escape byte ended the burst |

## Verification
- Timing of results:
  - Each sample, and the fall of `busy` at the end of a burst, is due on the clock edge that takes the strobe.
  - The bench drives each strobe for one clock and compares the outputs at the next falling edge.
  - `abort` is checked at that falling edge and again one clock later, when it must be back to 0.
- Expected stream: for every burst, the bench builds the full sample stream from the byte list. It applies the flag, escape, stuffing and NRZI rules and steps a phase of its own. It then compares each strobe's sample, allowing one count of rounding in the sine.
- Start pulse during a burst (R12): this pulse is issued between strobes. The bench checks it by confirming that the following samples still match the uninterrupted stream.

// File: rtl/fsk_burst_pkg.sv
package fsk_burst_pkg;

    localparam logic [7:0] FLAG_BYTE  = 8'h7E;
    localparam logic [7:0] ABORT_BYTE = 8'h7F;
    localparam logic [7:0] ESC_BYTE   = 8'h1B;

    localparam int PHASE_W = 9;                 // 512 phase steps per period
    localparam int QTR_N   = 2 ** (PHASE_W - 2); // stored quarter-wave entries
    localparam int SMP_W   = 8;

    // Quarter-wave value round(128 + 127*sin(pi*i/256)) from an integer
    // Taylor series in Q28 fixed point.
    function automatic logic [SMP_W-1:0] quarter_sine(input int unsigned i);
        longint x, x2, t, s;
        x  = (longint'(i) * 64'sd843314857) >>> 8;   // pi * 2^28 / 256 * i
        x2 = (x * x) >>> 28;
        t  = x;
        s  = x;
        for (int k = 1; k <= 4; k++) begin
            t = -((t * x2) >>> 28) / longint'((2 * k) * (2 * k + 1));
            s = s + t;
        end
        return SMP_W'(128 + ((127 * s + (64'sd1 <<< 27)) >>> 28));
    endfunction

endpackage

// File: rtl/fsk_sine_lut.sv
module fsk_sine_lut
    import fsk_burst_pkg::*;
(
    input  logic [PHASE_W-1:0] phase,
    output logic [SMP_W-1:0]   value
);
    localparam int IDX_W = PHASE_W - 2;

    logic [SMP_W-1:0] qtab [QTR_N];

    for (genvar g = 0; g < QTR_N; g++) begin : g_tab
        assign qtab[g] = quarter_sine(g);
    end

    logic [IDX_W-1:0] idx;
    logic [SMP_W-1:0] mag;

    always_comb begin
        // second quarter mirrors the first: 255 - r == ~r[6:0] for r >= 128
        idx   = phase[PHASE_W-2] ? ~phase[IDX_W-1:0] : phase[IDX_W-1:0];
        mag   = qtab[idx];
        value = phase[PHASE_W-1] ? ~mag : mag;
    end

endmodule

// File: rtl/fsk_bit_framer.sv
module fsk_bit_framer
    import fsk_burst_pkg::*;
#(
    parameter int SPB    = 8,
    parameter int PRE_N  = 3,
    parameter int TAIL_N = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strobe,
    input  logic       start,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    output logic       in_ready,
    output logic       step_o,
    output logic       halt_o,
    output logic       restart_o,
    output logic       tone_nx_o,
    output logic       busy_o,
    output logic       abort_o
);
    localparam int SIDX_W = (SPB > 1) ? $clog2(SPB) : 1;
    localparam int PRE_W  = (PRE_N > 0) ? $clog2(PRE_N + 1) : 1;
    localparam int TAIL_W = (TAIL_N > 0) ? $clog2(TAIL_N + 1) : 1;

    typedef struct packed {
        logic              busy;
        logic              abort;
        logic              hold_v;
        logic [7:0]        hold_b;
        logic [7:0]        cur_b;
        logic [7:0]        mask;
        logic [3:0]        ones;
        logic              sok;     // current byte may be stuffed
        logic              tone;    // 0 mark, 1 space
        logic [SIDX_W-1:0] sidx;
        logic [PRE_W-1:0]  pre;
        logic [TAIL_W-1:0] tail;
    } fr_t;

    fr_t fr_d, fr_q;

    logic [7:0] pick;
    logic       take_hold, take_direct, stop, esc_fail;

    always_comb begin
        fr_d        = fr_q;
        fr_d.abort  = 1'b0;
        step_o      = 1'b0;
        halt_o      = 1'b0;
        restart_o   = 1'b0;
        take_hold   = 1'b0;
        take_direct = 1'b0;
        stop        = 1'b0;
        esc_fail    = 1'b0;
        pick        = fr_q.cur_b;

        if (strobe && fr_q.busy) begin
            if (fr_q.sidx == '0) begin
                if (fr_q.mask == '0) begin
                    if (!fr_q.hold_v && fr_q.tail == '0) begin
                        stop = 1'b1;
                    end else begin
                        if (!fr_q.sok) fr_d.ones = '0;
                        fr_d.sok = 1'b1;
                        if (fr_q.pre != '0) begin
                            fr_d.pre = fr_q.pre - PRE_W'(1);
                            pick     = FLAG_BYTE;
                        end else if (!fr_q.hold_v) begin
                            fr_d.tail = fr_q.tail - TAIL_W'(1);
                            pick      = FLAG_BYTE;
                        end else begin
                            pick      = fr_q.hold_b;
                            take_hold = 1'b1;
                        end
                        if (take_hold && pick == ESC_BYTE) begin
                            if (in_valid) begin
                                pick        = in_data;
                                take_direct = 1'b1;
                            end else begin
                                stop     = 1'b1;
                                esc_fail = 1'b1;
                            end
                        end else if (pick == FLAG_BYTE || pick == ABORT_BYTE) begin
                            fr_d.sok = 1'b0;
                        end
                        fr_d.cur_b = pick;
                        fr_d.mask  = 8'h01;
                    end
                end
                if (!stop) begin
                    if (fr_d.sok && fr_d.ones >= 4'd5) begin
                        fr_d.ones = '0;
                        fr_d.tone = ~fr_d.tone;
                    end else begin
                        if ((fr_d.cur_b & fr_d.mask) != 8'h00) begin
                            if (fr_d.ones != 4'hF) fr_d.ones = fr_d.ones + 4'd1;
                        end else begin
                            fr_d.ones = '0;
                            fr_d.tone = ~fr_d.tone;
                        end
                        fr_d.mask = fr_d.mask << 1;
                    end
                    fr_d.sidx = SIDX_W'(SPB - 1);
                    step_o    = 1'b1;
                end
            end else begin
                fr_d.sidx = fr_q.sidx - SIDX_W'(1);
                step_o    = 1'b1;
            end
            if (stop) begin
                fr_d.busy  = 1'b0;
                fr_d.abort = esc_fail;
                fr_d.mask  = '0;
                fr_d.sidx  = '0;
                halt_o     = 1'b1;
            end
        end

        in_ready = !fr_q.hold_v || take_hold;
        if (take_direct) begin
            fr_d.hold_v = 1'b0;
        end else if (in_ready) begin
            fr_d.hold_v = in_valid;
            fr_d.hold_b = in_data;
        end

        if (start) begin
            fr_d.tail = TAIL_W'(TAIL_N);
            if (!fr_q.busy) begin
                fr_d.busy = 1'b1;
                fr_d.tone = 1'b0;
                fr_d.ones = '0;
                fr_d.sok  = 1'b1;
                fr_d.mask = '0;
                fr_d.sidx = '0;
                fr_d.pre  = PRE_W'(PRE_N);
                restart_o = 1'b1;
            end
        end

        tone_nx_o = fr_d.tone;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    assign busy_o  = fr_q.busy;
    assign abort_o = fr_q.abort;

    // R6: a stuffable byte never carries a run longer than five ones
    a_r6_ones_limit: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.sok |-> (fr_q.ones <= 4'd5));

    // R4: the tone moves only when a new line bit begins
    a_r4_tone_on_bit_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (fr_q.tone != $past(fr_q.tone)) |-> ($past(fr_q.sidx) == '0));

    // R11: abort is a single clock and only while idle
    a_r11_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.abort |=> !fr_q.abort);
    a_r11_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        fr_q.abort |-> !fr_q.busy);

endmodule

// File: rtl/fsk_burst_tx.sv
module fsk_burst_tx
    import fsk_burst_pkg::*;
#(
    parameter int SAMPLE_HZ = 9600,
    parameter int BAUD_HZ   = 1200,
    parameter int MARK_HZ   = 1200,
    parameter int SPACE_HZ  = 2200,
    parameter int PRE_MS    = 20,
    parameter int TAIL_MS   = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample_en,
    input  logic       start,
    input  logic [7:0] byte_data,
    input  logic       byte_valid,
    output logic       byte_ready,
    output logic [7:0] sample_out,
    output logic       busy,
    output logic       abort
);
    localparam int SPB      = SAMPLE_HZ / BAUD_HZ;
    localparam int PRE_N    = (PRE_MS * BAUD_HZ + 4000) / 8000;
    localparam int TAIL_N   = (TAIL_MS * BAUD_HZ + 4000) / 8000;
    localparam int MARK_INC  = ((2 ** PHASE_W) * MARK_HZ + SAMPLE_HZ / 2) / SAMPLE_HZ;
    localparam int SPACE_INC = ((2 ** PHASE_W) * SPACE_HZ + SAMPLE_HZ / 2) / SAMPLE_HZ;

    typedef struct packed {
        logic [PHASE_W-1:0] acc;
        logic [SMP_W-1:0]   smp;
    } tg_t;

    tg_t tg_d, tg_q;

    logic step, halt, restart, tone_nx;
    logic [PHASE_W-1:0] phase_nx;
    logic [SMP_W-1:0]   lut_val;

    fsk_bit_framer #(.SPB(SPB), .PRE_N(PRE_N), .TAIL_N(TAIL_N)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe    (sample_en),
        .start     (start),
        .in_data   (byte_data),
        .in_valid  (byte_valid),
        .in_ready  (byte_ready),
        .step_o    (step),
        .halt_o    (halt),
        .restart_o (restart),
        .tone_nx_o (tone_nx),
        .busy_o    (busy),
        .abort_o   (abort)
    );

    assign phase_nx = tg_q.acc + (tone_nx ? PHASE_W'(SPACE_INC) : PHASE_W'(MARK_INC));

    fsk_sine_lut u_lut (
        .phase (phase_nx),
        .value (lut_val)
    );

    always_comb begin
        tg_d = tg_q;
        if (restart) tg_d.acc = '0;
        if (step) begin
            tg_d.acc = phase_nx;
            tg_d.smp = lut_val;
        end else if (halt) begin
            tg_d.smp = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tg_q <= '0;
        else        tg_q <= tg_d;
    end

    assign sample_out = tg_q.smp;

    // R10: no tone leaves the block while idle
    a_r10_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (sample_out == '0));

    // R3: the phase moves only on a strobe
    a_r3_acc_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_en && !start) |=> $stable(tg_q.acc));

endmodule

// File: tb/fsk_burst_tx_test.sv
module fsk_burst_tx_test;

    localparam int BENCH_SPB = 9600 / 1200;
    localparam int PRE_N     = (20 * 1200 + 4000) / 8000;   // 3
    localparam int TAIL_N    = (10 * 1200 + 4000) / 8000;   // 2
    localparam int MARK_STEP  = (512 * 1200 + 4800) / 9600;  // 64
    localparam int SPACE_STEP = (512 * 2200 + 4800) / 9600;  // 117

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_en = 1'b0;
    logic       start = 1'b0;
    logic [7:0] byte_data = '0;
    logic       byte_valid = 1'b0;
    logic       byte_ready;
    logic [7:0] sample_out;
    logic       busy;
    logic       abort;

    int checks = 0;
    int errors = 0;

    int qb [300];
    int exp_s [32768];
    int fidx = 0;
    int fn = 0;

    int m_tone, m_ones, m_acc, m_ns;
    bit m_prev_sf;

    always #5 clk = ~clk;

    fsk_burst_tx #(
        .SAMPLE_HZ(9600), .BAUD_HZ(1200), .MARK_HZ(1200), .SPACE_HZ(2200),
        .PRE_MS(20), .TAIL_MS(10)
    ) uut (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .start(start),
        .byte_data(byte_data), .byte_valid(byte_valid), .byte_ready(byte_ready),
        .sample_out(sample_out), .busy(busy), .abort(abort)
    );

    function automatic int ref_sine(int p);
        int r = p % 256;
        int i = (r >= 128) ? 255 - r : r;
        real v = 128.0 + 127.0 * $sin(3.14159265358979 * i / 256.0);
        int t = $rtoi(v + 0.5);
        return (p >= 256) ? 255 - t : t;
    endfunction

    task automatic chk(string tag, int act, int exp, int tol);
        int diff = act - exp;
        checks++;
        if (diff > tol || diff < -tol) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one line bit: 8 strobes on the current tone
    task automatic emit_period();
        for (int s = 0; s < BENCH_SPB; s++) begin
            m_acc = (m_acc + (m_tone != 0 ? SPACE_STEP : MARK_STEP)) % 512;
            exp_s[m_ns] = ref_sine(m_acc);
            m_ns++;
        end
    endtask

    task automatic emit_byte(int b, bit sf);
        if (!m_prev_sf) m_ones = 0;
        for (int k = 0; k < 8; k++) begin
            if (sf && m_ones >= 5) begin
                m_tone ^= 1;
                m_ones = 0;
                emit_period();
            end
            if (((b >> k) & 1) != 0) m_ones++;
            else begin
                m_ones = 0;
                m_tone ^= 1;
            end
            emit_period();
        end
        m_prev_sf = sf;
    endtask

    task automatic build(int n, output int ns, output bit ab);
        int idx = 0;
        int b;
        bit sf;
        m_tone = 0; m_ones = 0; m_acc = 0; m_ns = 0; m_prev_sf = 1'b1;
        ab = 1'b0;
        for (int p = 0; p < PRE_N; p++) emit_byte(8'h7E, 1'b0);
        while (idx < n && !ab) begin
            b = qb[idx]; idx++;
            sf = 1'b1;
            if (b == 8'h1B) begin
                if (idx >= n) ab = 1'b1;
                else begin b = qb[idx]; idx++; end
            end else if (b == 8'h7E || b == 8'h7F) begin
                sf = 1'b0;
            end
            if (!ab) emit_byte(b, sf);
        end
        if (!ab) for (int t = 0; t < TAIL_N; t++) emit_byte(8'h7E, 1'b0);
        ns = m_ns;
    endtask

    task automatic tick(logic se, logic st);
        bit fire;
        sample_en = se;
        start = st;
        #1;
        fire = byte_valid && byte_ready;
        @(posedge clk);
        #1;
        if (fire) fidx++;
        byte_valid = (fidx < fn);
        byte_data = (fidx < fn) ? 8'(qb[fidx]) : 8'h00;
        sample_en = 1'b0;
        start = 1'b0;
        @(negedge clk);
    endtask

    task automatic strobe();
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
    endtask

    task automatic run(string tag, int n, int mid);
        int ns;
        bit ab;
        build(n, ns, ab);
        fidx = 0;
        fn = n;
        byte_valid = (n > 0);
        byte_data = (n > 0) ? 8'(qb[0]) : 8'h00;
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        // R13: holding stage full once a byte waits
        chk({tag, " R13 ready"}, int'(byte_ready), (n > 0) ? 0 : 1, 0);
        tick(1'b0, 1'b1);
        chk({tag, " R5 start"}, int'(busy), 1, 0);
        for (int k = 0; k < ns; k++) begin
            if (k == mid && k > 0) begin
                tick(1'b0, 1'b1);
                chk({tag, " R12 start ignored"}, int'(sample_out), exp_s[k-1], 1);
            end
            strobe();
            chk(tag, int'(sample_out), exp_s[k], 1);
            chk({tag, " busy"}, int'(busy), 1, 0);
        end
        tick(1'b1, 1'b0);
        chk({tag, " R10 busy end"}, int'(busy), 0, 0);
        chk({tag, " R10 silent"}, int'(sample_out), 0, 0);
        chk({tag, " R11 abort"}, int'(abort), int'(ab), 0);
        tick(1'b0, 1'b0);
        chk({tag, " R11 abort width"}, int'(abort), 0, 0);
        chk({tag, " R13 drained"}, fidx, n, 0);
        strobe();
        chk({tag, " R10 idle"}, int'(sample_out), 0, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 busy", int'(busy), 0, 0);
        chk("R1 abort", int'(abort), 0, 0);
        chk("R1 sample", int'(sample_out), 0, 0);
        chk("R1 ready", int'(byte_ready), 1, 0);

        // R9: preamble and tail only
        run("R9 flags only", 0, -1);

        // R5: NRZI with LSB first
        qb[0] = 8'h55; qb[1] = 8'h00; qb[2] = 8'hA3;
        run("R5 nrzi", 3, -1);

        // R6: stuffing including runs across byte boundaries
        qb[0] = 8'hFF; qb[1] = 8'hFF; qb[2] = 8'h3E; qb[3] = 8'hF8;
        run("R6 stuffing", 4, -1);

        // R7: raw flag and abort bytes go out unstuffed
        qb[0] = 8'h41; qb[1] = 8'h7E; qb[2] = 8'h7F; qb[3] = 8'hFF; qb[4] = 8'h7F;
        run("R7 raw markers", 5, -1);

        // R8: escape protects the next byte
        qb[0] = 8'h1B; qb[1] = 8'h7E; qb[2] = 8'h1B; qb[3] = 8'h1B;
        qb[4] = 8'h1B; qb[5] = 8'h7F; qb[6] = 8'h22;
        run("R8 escape", 7, -1);

        // R2/R3/R4 sweep over every byte value, with a start pulse mid-burst (R12)
        for (int i = 0; i < 256; i++) qb[i] = i;
        run("R2/R3/R4 sweep", 256, 600);

        // R11: escape with nothing behind it
        qb[0] = 8'h33; qb[1] = 8'h1B;
        run("R11 escape at end", 2, -1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule